// File: doc/BRIEF.md
# Indexed Register Access Port with Auto-Increment

This block lets a host reach a byte-wide internal register space of up to 64K locations through four narrow host registers. Two of them hold the low and high bytes of a 16-bit index. A third holds a control flag. The fourth is a data window: a host write or read of the window reaches the internal location the index currently selects.

When the control flag is set, every access to the data window advances the index by one. Large blocks, such as a 1024-byte cursor image, can then stream in or out with one index setup followed by back-to-back data accesses. The index and control registers read back, so driver code can save them, run its own sequence and restore them afterwards.

Only the internal locations below a parameterised limit exist. The port masks writes to locations above the limit and returns zero for reads from them.

Top module: `idx_reg_port`

## Requirements
- R1: After reset the index is 0x0000, auto-increment is off, `host_rvalid` is 0 and `host_rdata` is 0.
- R2: Host register selects are: 0 index low byte, 1 index high byte, 2 control, 3 data window. Writing select 0 or 1 loads bits 7:0 or 15:8 of the index from `host_wdata[7:0]`, and upper write bits are ignored. Reading either returns that byte, and `reg_addr` always shows the full index.
- R3: Bit 0 of a control write sets auto-increment (1 = on). Reading the control register returns that bit in bit 0 with all other bits zero.
- R4: In the cycle of a data-window write, `reg_we` is 1, `reg_addr` equals the index and `reg_wdata` equals `host_wdata[7:0]`. `reg_we` is never 1 at any other time.
- R5: A read of any host register gives `host_rvalid` = 1 in the next cycle, with the value in `host_rdata[7:0]` and bits 31:8 zero. A data-window read returns the internal byte at the index as it stood during the strobe.
- R6: With auto-increment off, data-window accesses leave the index unchanged, so repeated accesses hit one location.
- R7: With auto-increment on, each data-window read or write advances the index by one after the access, carrying from the low byte into the high byte.
- R8: An auto-increment from 0xFFFF wraps the index to 0x0000.
- R9: At an index at or above LIMIT, a data write does not raise `reg_we` and a data read returns zero, whatever `reg_rdata` shows.
- R10: Accesses to the index and control registers never move the index through auto-increment and never raise `reg_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | One-cycle host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read, qualified by host_sel |
| host_reg | input | 2 | Host register select (0 low, 1 high, 2 control, 3 data) |
| host_wdata | input | 32 | Host write data; only bits 7:0 used |
| host_rdata | output | 32 | Registered read data, bits 31:8 zero |
| host_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| reg_addr | output | 16 | Internal address (current index) |
| reg_wdata | output | 8 | Internal write data |
| reg_we | output | 1 | Internal write enable |
| reg_rdata | input | 8 | Internal read data, combinational from reg_addr |

## Verification
The assertions assume that the host strobe lasts exactly one cycle per access, that `host_wr` and `host_reg` are stable while it is high, and that `reg_rdata` settles within the cycle after `reg_addr` changes. The bench drives every access as a single-cycle strobe set up away from the clock edge. Its internal-space model answers combinationally, and it returns a non-zero filler byte above LIMIT, so the zeroing of out-of-range reads is visible at the host port.

// File: rtl/idx_reg_port.sv
module idx_reg_port #(
  parameter int HOST_W = 32,
  parameter int LIMIT  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [1:0]        host_reg,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [15:0]       reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata
);
  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  logic [15:0] idx;
  logic        auto_inc;
  logic [7:0]  rd_byte;

  wire data_acc = host_sel && (host_reg == SEL_DATA);
  wire in_range = (32'(idx) < LIMIT);

  assign reg_addr  = idx;
  assign reg_wdata = host_wdata[7:0];
  assign reg_we    = data_acc && host_wr && in_range;

  always_comb begin
    case (host_reg)
      SEL_LO:  rd_byte = idx[7:0];
      SEL_HI:  rd_byte = idx[15:8];
      SEL_CTL: rd_byte = {7'd0, auto_inc};
      default: rd_byte = in_range ? reg_rdata : 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx         <= '0;
      auto_inc    <= 1'b0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_sel && !host_wr;
      if (host_sel && !host_wr)
        host_rdata <= {{(HOST_W-8){1'b0}}, rd_byte};
      if (host_sel && host_wr) begin
        case (host_reg)
          SEL_LO:  idx[7:0]  <= host_wdata[7:0];
          SEL_HI:  idx[15:8] <= host_wdata[7:0];
          SEL_CTL: auto_inc  <= host_wdata[0];
          default: ;
        endcase
      end
      if (data_acc && auto_inc)
        idx <= idx + 16'd1;
    end
  end
endmodule

// File: rtl/idx_reg_port_chk.sv
module idx_reg_port_chk #(
  parameter int HOST_W = 32,
  parameter int LIMIT  = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [1:0]        host_reg,
  input logic [HOST_W-1:0] host_rdata,
  input logic              host_rvalid,
  input logic [15:0]       reg_addr,
  input logic              reg_we,
  input logic              auto_inc
);
  // R4
  we_only_on_data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (host_sel && host_wr && host_reg == 2'd3));

  // R9
  we_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (32'(reg_addr) < LIMIT));

  // R5
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr) |=> host_rvalid);

  // R5
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> (host_rdata[HOST_W-1:8] == '0));

  // R7
  step_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_reg == 2'd3 && auto_inc) |=> (reg_addr == $past(reg_addr) + 16'd1));

  // R6
  hold_without_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_reg == 2'd3 && !auto_inc) |=> $stable(reg_addr));

  // R10
  hold_on_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_wr && host_reg != 2'd3) |=> $stable(reg_addr));
endmodule

bind idx_reg_port idx_reg_port_chk #(.HOST_W(HOST_W), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_reg(host_reg), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .reg_addr(reg_addr), .reg_we(reg_we), .auto_inc(auto_inc)
);

// File: tb/idx_reg_port_tb.sv
`timescale 1ns/1ps
module idx_reg_port_tb;
  localparam int LIMIT = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_reg = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_we;
  logic [7:0]  reg_rdata;

  logic [7:0] mem [0:LIMIT-1];

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        seen_we;
  logic [15:0] seen_addr;
  logic [7:0]  seen_wdata;

  always #2.5 clk = ~clk;

  idx_reg_port #(.LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk) if (reg_we) mem[reg_addr[9:0]] <= reg_wdata;
  assign reg_rdata = (32'(reg_addr) < LIMIT) ? mem[reg_addr[9:0]] : 8'hA5;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] r, input logic [31:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_reg = r; host_wdata = v;
    #1;
    seen_we = reg_we; seen_addr = reg_addr; seen_wdata = reg_wdata;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] r, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_reg = r;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) check("R5 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic set_index(input logic [15:0] a);
    host_write(2'd0, {24'hFFFFFF, a[7:0]});
    host_write(2'd1, {24'hABCDEF, a[15:8]});
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rvalid", 32'(host_rvalid), 32'd0);
    check("R1 rdata", host_rdata, 32'd0);
    check("R1 addr", 32'(reg_addr), 32'd0);
    host_read(2'd2, 32'd0, "R1 ctl");
    host_read(2'd0, 32'd0, "R1 lo");

    // R2 index bytes, upper write bits ignored
    set_index(16'h0234);
    check("R2 addr", 32'(reg_addr), 32'h0234);
    host_read(2'd0, 32'h34, "R2 lo");
    host_read(2'd1, 32'h02, "R2 hi");

    // R3 control bit 0 only
    host_write(2'd2, 32'hFE);
    host_read(2'd2, 32'd0, "R3 ctl off");

    // R4 / R6 data write, no increment
    host_write(2'd3, 32'hFFFF_FF5A);
    check("R4 we", 32'(seen_we), 32'd1);
    check("R4 addr", 32'(seen_addr), 32'h0234);
    check("R4 wdata", 32'(seen_wdata), 32'h5A);
    check("R6 hold", 32'(reg_addr), 32'h0234);
    host_write(2'd3, 32'h5B);
    host_read(2'd3, 32'h5B, "R5 R6 same location");
    check("R6 hold after read", 32'(reg_addr), 32'h0234);

    // R7 carry across low byte
    host_write(2'd2, 32'h01);
    host_read(2'd2, 32'h01, "R3 ctl on");
    set_index(16'h00FE);
    host_write(2'd3, 32'h11);
    host_write(2'd3, 32'h22);
    host_write(2'd3, 32'h33);
    check("R7 addr", 32'(reg_addr), 32'h0101);
    host_read(2'd0, 32'h01, "R7 R10 lo");
    host_read(2'd1, 32'h01, "R7 R10 hi");
    host_write(2'd2, 32'h01);
    check("R10 ctl write no we", 32'(seen_we), 32'd0);
    check("R10 addr", 32'(reg_addr), 32'h0101);
    set_index(16'h00FE);
    host_read(2'd3, 32'h11, "R7 read FE");
    host_read(2'd3, 32'h22, "R7 read FF");
    host_read(2'd3, 32'h33, "R7 read 100");
    check("R7 addr after reads", 32'(reg_addr), 32'h0101);

    // R7 block load of 1024 bytes
    set_index(16'h0000);
    for (int i = 0; i < LIMIT; i++) host_write(2'd3, 32'((i * 7 + 3) & 8'hFF));
    check("R7 addr after block", 32'(reg_addr), 32'h0400);
    set_index(16'h0000);
    for (int i = 0; i < LIMIT; i++) host_read(2'd3, 32'((i * 7 + 3) & 8'hFF), "R7 block read");

    // R9 out of range
    set_index(16'h0400);
    host_write(2'd3, 32'h77);
    check("R9 no we", 32'(seen_we), 32'd0);
    check("R9 still steps", 32'(reg_addr), 32'h0401);
    set_index(16'h0400);
    host_read(2'd3, 32'h00, "R9 read zero");

    // R8 wrap
    set_index(16'hFFFF);
    host_write(2'd3, 32'h99);
    check("R8 wrap", 32'(reg_addr), 32'h0000);
    host_read(2'd1, 32'h00, "R8 hi");
    host_read(2'd3, 32'h03, "R8 read at 0");

    repeat (3) @(negedge clk);
    check("R5 all reads returned", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule